// File: doc/BRIEF.md
# Programmable Video Timing Generator

The block produces the raster timing for a display pipeline from one pixel clock: horizontal sync, vertical sync, a data-enable that marks visible pixels, a field indicator, and the current pixel column and line numbers. Every line is laid out as front porch, sync pulse, back porch, then the visible region last. The line length doubles as the end of the visible region, so a line is `line total` pixels long and the visible width is `line total - active begin`.

It runs in progressive mode, with one vertical window set, or in interlaced mode. In interlaced mode a second field follows the first inside the same frame. That second field has its own visible window and its own vertical sync, and the edges of that sync fall part-way along a line, at a programmable pixel offset. Software programs the timing through a simple write port. The values land in shadow registers, and the counters only start using them at the first pixel of a frame, so no frame ever mixes two timings. One enable bit starts and stops the raster. It takes effect at once.

Top module: `vtg_top`

## Requirements
- R1: After reset every timing register and control bit is zero, the generator is stopped, xPos and yPos are 0, and de, field, hSync and vSync are all 0.
- R2: While running, xPos counts 0 up to line total - 1 and then returns to 0. yPos advances by one each time xPos returns to 0. yPos returns to 0 after line frame total - 1, where frame total is vAct0End in progressive mode and vAct1End in interlaced mode.
- R3: The horizontal pulse is asserted while hSyncBeg <= xPos < hSyncEnd. A polarity bit of 0 drives the pulse high. A polarity bit of 1 drives it low, with the line high otherwise. The two polarity bits are separate.
- R4: In progressive mode, de is 1 exactly when hActBeg <= xPos < line total and vAct0Beg <= yPos < vAct0End.
- R5: The first vertical pulse starts at pixel hSyncBeg of line vSync0Beg and ends at pixel hSyncBeg of line vSync0End. Its polarity follows the vertical polarity bit.
- R6: In interlaced mode the vertical visible condition is the OR of the window vAct0Beg..vAct0End-1 and the window vAct1Beg..vAct1End-1. The frame is vAct1End lines long.
- R7: In interlaced mode a second vertical pulse starts at pixel hSyncBeg + vSyncOff of line vSync1Beg and ends at the same pixel of line vSync1End.
- R8: field is 1 (bottom) while running in interlaced mode on lines yPos >= vAct0End or yPos < vSync0Beg, and 0 otherwise. In progressive mode field is always 0.
- R9: A timing write made while the raster runs does not change the current frame. It takes effect from pixel 0 of line 0 of the next frame. Writes made while the generator is stopped take effect at once.
- R10: The enable bit acts on the next clock. Clearing it stops the counters, which read 0 one clock later. It forces de and field to 0 and holds each sync at its inactive level. Setting it starts the raster at xPos 0, yPos 0.
- R11: Write address map, 12-bit data: 0 control (bit0 enable, bit1 interlace, bit2 horizontal polarity, bit3 vertical polarity); 1 line total; 2 hActBeg; 3 hSyncBeg; 4 hSyncEnd; 5 vAct0Beg; 6 vAct0End; 7 vSync0Beg; 8 vSync0End; 9 vAct1Beg; 10 vAct1End; 11 vSync1Beg; 12 vSync1End; 13 vSyncOff. Other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 12 | Register write data |
| hSync | output | 1 | Horizontal sync, polarity applied |
| vSync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Visible-pixel enable |
| field | output | 1 | Field indicator, 1 = bottom field |
| xPos | output | 12 | Pixel column counter |
| yPos | output | 12 | Line counter |

## Verification
The assertions check four things on every cycle. While stopped, the outputs are quiet and the counters are zero. The column steps by one and wraps after the last pixel of the line. de never lies outside the horizontal visible window. The working timing stays frozen everywhere except at pixel 0 of line 0. Other behaviour depends on the programmed sequence and only the bench's scenarios can show it. This covers the mid-line edges of the second field's vertical pulse, the field indicator's wrap across the frame boundary, a timing write deferred to the next frame, and a restart from 0,0 after the raster is stopped. A behavioural model in the bench predicts every output on every clock through those scenarios.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int TW = 12;   // counter and timing field width
  localparam int AW = 4;    // write address width
  localparam int NF = 2;    // fields per interlaced frame

  typedef logic [TW-1:0] cnt_t;

  typedef enum logic [AW-1:0] {
    A_CTRL      = 4'd0,
    A_LINE_TOT  = 4'd1,
    A_HACT_BEG  = 4'd2,
    A_HSYNC_BEG = 4'd3,
    A_HSYNC_END = 4'd4,
    A_VACT0_BEG = 4'd5,
    A_VACT0_END = 4'd6,
    A_VSYN0_BEG = 4'd7,
    A_VSYN0_END = 4'd8,
    A_VACT1_BEG = 4'd9,
    A_VACT1_END = 4'd10,
    A_VSYN1_BEG = 4'd11,
    A_VSYN1_END = 4'd12,
    A_VSYN_OFF  = 4'd13
  } reg_addr_e;

  typedef struct packed {
    logic intl;
    logic hPol;
    logic vPol;
    cnt_t hActEnd;
    cnt_t hActBeg;
    cnt_t hSyncBeg;
    cnt_t hSyncEnd;
    cnt_t vAct0Beg;
    cnt_t vAct0End;
    cnt_t vSync0Beg;
    cnt_t vSync0End;
    cnt_t vAct1Beg;
    cnt_t vAct1End;
    cnt_t vSync1Beg;
    cnt_t vSync1End;
    cnt_t vSyncOff;
  } timing_t;

  typedef struct packed {
    logic run;       // counters advance, outputs live
    logic lineWrap;  // column returns to 0 at this edge
    logic frameWrap; // line returns to 0 at this edge
    logic load;      // working timing takes the shadow value
  } strobe_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  cnt_t          wrData,
  input  logic          load,
  output logic          enLive,
  output timing_t       wkCfg
);
  timing_t shCfg;
  timing_t shNext;
  logic    enNext;

  always_comb begin
    shNext = shCfg;
    enNext = enLive;
    if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          enNext      = wrData[0];
          shNext.intl = wrData[1];
          shNext.hPol = wrData[2];
          shNext.vPol = wrData[3];
        end
        A_LINE_TOT:  shNext.hActEnd   = wrData;
        A_HACT_BEG:  shNext.hActBeg   = wrData;
        A_HSYNC_BEG: shNext.hSyncBeg  = wrData;
        A_HSYNC_END: shNext.hSyncEnd  = wrData;
        A_VACT0_BEG: shNext.vAct0Beg  = wrData;
        A_VACT0_END: shNext.vAct0End  = wrData;
        A_VSYN0_BEG: shNext.vSync0Beg = wrData;
        A_VSYN0_END: shNext.vSync0End = wrData;
        A_VACT1_BEG: shNext.vAct1Beg  = wrData;
        A_VACT1_END: shNext.vAct1End  = wrData;
        A_VSYN1_BEG: shNext.vSync1Beg = wrData;
        A_VSYN1_END: shNext.vSync1End = wrData;
        A_VSYN_OFF:  shNext.vSyncOff  = wrData;
        default: ;
      endcase
    end
  end

  // The shadow always takes writes. The working copy takes the shadow,
  // including a write in the same cycle, only on the load strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shCfg  <= '0;
      wkCfg  <= '0;
      enLive <= 1'b0;
    end else begin
      shCfg  <= shNext;
      enLive <= enNext;
      if (load) wkCfg <= shNext;
    end
  end
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic    enLive,
  input  logic    lineLast,
  input  logic    frameLast,
  output strobe_t st
);
  always_comb begin
    st.run       = enLive;
    st.lineWrap  = enLive && lineLast;
    st.frameWrap = enLive && frameLast;
    // stopped: timing follows the shadow; running: swap only at frame end
    st.load      = !enLive || frameLast;
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  timing_t wk,
  input  strobe_t st,
  output logic    lineLast,
  output logic    frameLast,
  output cnt_t    xPos,
  output cnt_t    yPos,
  output logic    hSync,
  output logic    vSync,
  output logic    de,
  output logic    field
);
  cnt_t hCnt;
  cnt_t vCnt;
  cnt_t hLastIdx;
  cnt_t vTotal;
  cnt_t vLastIdx;

  // (line, pixel) position is at or beyond (lineRef, pixRef)
  function automatic logic atOrAfter(cnt_t v, cnt_t h, cnt_t lineRef, cnt_t pixRef);
    return (v > lineRef) || ((v == lineRef) && (h >= pixRef));
  endfunction

  assign hLastIdx  = wk.hActEnd - cnt_t'(1);
  assign vTotal    = wk.intl ? wk.vAct1End : wk.vAct0End;
  assign vLastIdx  = vTotal - cnt_t'(1);
  assign lineLast  = hCnt >= hLastIdx;
  assign frameLast = lineLast && (vCnt >= vLastIdx);

  always_ff @(posedge clk) begin
    if (!rstN || !st.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (st.lineWrap) begin
      hCnt <= '0;
      vCnt <= st.frameWrap ? '0 : vCnt + cnt_t'(1);
    end else begin
      hCnt <= hCnt + cnt_t'(1);
    end
  end

  // per-field vertical windows
  cnt_t fActBeg  [NF];
  cnt_t fActEnd  [NF];
  cnt_t fSyncBeg [NF];
  cnt_t fSyncEnd [NF];
  cnt_t fEdgePix [NF];
  logic fOn      [NF];
  logic fAct     [NF];
  logic fSync    [NF];

  always_comb begin
    fActBeg[0]  = wk.vAct0Beg;   fActEnd[0]  = wk.vAct0End;
    fSyncBeg[0] = wk.vSync0Beg;  fSyncEnd[0] = wk.vSync0End;
    fEdgePix[0] = wk.hSyncBeg;   fOn[0]      = 1'b1;
    fActBeg[1]  = wk.vAct1Beg;   fActEnd[1]  = wk.vAct1End;
    fSyncBeg[1] = wk.vSync1Beg;  fSyncEnd[1] = wk.vSync1End;
    fEdgePix[1] = wk.hSyncBeg + wk.vSyncOff;
    fOn[1]      = wk.intl;
  end

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign fAct[f]  = fOn[f] && (vCnt >= fActBeg[f]) && (vCnt < fActEnd[f]);
    assign fSync[f] = fOn[f] && atOrAfter(vCnt, hCnt, fSyncBeg[f], fEdgePix[f])
                             && !atOrAfter(vCnt, hCnt, fSyncEnd[f], fEdgePix[f]);
  end

  logic vActAny;
  logic vSyncAny;
  always_comb begin
    vActAny  = 1'b0;
    vSyncAny = 1'b0;
    for (int f = 0; f < NF; f++) begin
      vActAny  = vActAny  | fAct[f];
      vSyncAny = vSyncAny | fSync[f];
    end
  end

  logic hActive;
  logic hPulse;
  logic botField;
  assign hActive  = (hCnt >= wk.hActBeg) && (hCnt < wk.hActEnd);
  assign hPulse   = (hCnt >= wk.hSyncBeg) && (hCnt < wk.hSyncEnd);
  assign botField = wk.intl && ((vCnt >= wk.vAct0End) || (vCnt < wk.vSync0Beg));

  assign hSync = (st.run && hPulse) ^ wk.hPol;
  assign vSync = (st.run && vSyncAny) ^ wk.vPol;
  assign de    = st.run && hActive && vActAny;
  assign field = st.run && botField;
  assign xPos  = hCnt;
  assign yPos  = vCnt;
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [TW-1:0] wrData,
  output logic          hSync,
  output logic          vSync,
  output logic          de,
  output logic          field,
  output logic [TW-1:0] xPos,
  output logic [TW-1:0] yPos
);
  logic    enLive;
  timing_t wkCfg;
  strobe_t st;
  logic    lineLast;
  logic    frameLast;

  vtg_regs i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .load(st.load), .enLive(enLive), .wkCfg(wkCfg)
  );

  vtg_ctrl i_ctrl (
    .enLive(enLive), .lineLast(lineLast), .frameLast(frameLast), .st(st)
  );

  vtg_datapath i_dp (
    .clk(clk), .rstN(rstN), .wk(wkCfg), .st(st),
    .lineLast(lineLast), .frameLast(frameLast),
    .xPos(xPos), .yPos(yPos), .hSync(hSync), .vSync(vSync),
    .de(de), .field(field)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    enLive,
  input timing_t wkCfg,
  input cnt_t    xPos,
  input cnt_t    yPos,
  input logic    hSync,
  input logic    de,
  input logic    field
);
  cnt_t lastPix;
  assign lastPix = wkCfg.hActEnd - cnt_t'(1);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enLive |-> (!de && !field && (hSync == wkCfg.hPol))); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !enLive |=> (xPos == '0 && yPos == '0)); // R10

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enLive && xPos < lastPix) |=> (!enLive || xPos == $past(xPos) + cnt_t'(1))); // R2

  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enLive && xPos == lastPix) |=> (!enLive || xPos == '0)); // R2

  AST_DE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    de |-> (xPos >= wkCfg.hActBeg && xPos < wkCfg.hActEnd)); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enLive && $past(enLive) && (xPos != '0 || yPos != '0)) |-> $stable(wkCfg)); // R9

  AST_FIELD_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (enLive && !wkCfg.intl) |-> !field); // R8
endmodule

bind vtg_top vtg_checker i_chk (
  .clk(clk), .rstN(rstN), .enLive(enLive), .wkCfg(wkCfg),
  .xPos(xPos), .yPos(yPos), .hSync(hSync), .de(de), .field(field)
);

// File: tb/test_vtg_top.sv
`timescale 1ns/1ps
module test_vtg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic        hSync, vSync, de, field;
  logic [11:0] xPos, yPos;

  vtg_top i_vtg_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSync(hSync), .vSync(vSync), .de(de), .field(field),
    .xPos(xPos), .yPos(yPos)
  );

  always #4 clk = ~clk; // 125 MHz

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    modelOn = 0;
  string phaseTag = "R1";

  // ---------------- behavioural reference model ----------------
  int mEn;
  int sh [0:13];
  int wk [0:13];
  int mh, mv;

  function automatic bit posAtOrAfter(int v, int h, int lv, int lh);
    return (v > lv) || (v == lv && h >= lh);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mh = 0; mv = 0;
      for (int i = 0; i < 14; i++) begin sh[i] = 0; wk[i] = 0; end
    end else begin
      int shn [0:13];
      int enn, tot, ll, fl;
      for (int i = 0; i < 14; i++) shn[i] = sh[i];
      enn = mEn;
      if (wrEn) begin
        if (wrAddr == 0) begin
          enn    = wrData[0];
          shn[0] = (wrData >> 1) & 7;
        end else if (wrAddr <= 13) shn[wrAddr] = wrData;
      end
      tot = (wk[0] & 1) ? wk[10] : wk[6];
      ll  = (mh >= ((wk[1] - 1) & 4095));
      fl  = ll && (mv >= ((tot - 1) & 4095));
      if (!mEn) begin mh = 0; mv = 0; end
      else if (ll) begin mh = 0; mv = fl ? 0 : ((mv + 1) & 4095); end
      else mh = mh + 1;
      if (!mEn || fl) for (int i = 0; i < 14; i++) wk[i] = shn[i];
      for (int i = 0; i < 14; i++) sh[i] = shn[i];
      mEn = enn;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (phase %s) act=%0d exp=%0d at x=%0d y=%0d t=%0t",
               tag, phaseTag, act, exp, xPos, yPos, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && modelOn && !done) begin
      int intl, hp, vp, hPul, vPul, vAct, eDe, eField, p1;
      intl = wk[0] & 1; hp = (wk[0] >> 1) & 1; vp = (wk[0] >> 2) & 1;
      p1   = (wk[3] + wk[13]) & 4095;
      hPul = (mh >= wk[3]) && (mh < wk[4]);
      vPul = (posAtOrAfter(mv, mh, wk[7], wk[3]) && !posAtOrAfter(mv, mh, wk[8], wk[3]))
          || (intl && posAtOrAfter(mv, mh, wk[11], p1) && !posAtOrAfter(mv, mh, wk[12], p1));
      vAct = (mv >= wk[5] && mv < wk[6]) || (intl && mv >= wk[9] && mv < wk[10]);
      eDe    = mEn && mh >= wk[2] && mh < wk[1] && vAct;
      eField = mEn && intl && (mv >= wk[6] || mv < wk[7]);
      cmp("R2 xPos", xPos, mh);
      cmp("R2 yPos", yPos, mv);
      cmp("R3 hSync", hSync, (mEn && hPul) ^ hp);
      cmp(intl ? "R7 vSync" : "R5 vSync", vSync, (mEn && vPul) ^ vp);
      cmp(intl ? "R6 de" : "R4 de", de, eDe);
      cmp("R8 field", field, eField);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = 12'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPos(int y, int x);
    int n = 0;
    while (!(yPos == 12'(y) && xPos == 12'(x)) && n < 4000) begin
      @(negedge clk); n++;
    end
    if (n >= 4000) cmp({phaseTag, " position reached"}, 0, 1);
  endtask

  task automatic runFrames(int n);
    repeat (n) begin
      @(negedge clk);
      waitPos(0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1;
      $finish;
    end
  end

  initial begin
    int cnt, maxX;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    phaseTag = "R1";
    cmp("R1 xPos", xPos, 0);  cmp("R1 yPos", yPos, 0);
    cmp("R1 de", de, 0);      cmp("R1 field", field, 0);
    cmp("R1 hSync", hSync, 0); cmp("R1 vSync", vSync, 0);
    modelOn = 1;

    // R11: program a progressive raster through the address map while stopped
    phaseTag = "R11";
    wr(1, 20); wr(2, 6); wr(3, 1); wr(4, 3);
    wr(5, 3);  wr(6, 12); wr(7, 1); wr(8, 2);
    wr(14, 5); wr(15, 7);   // unmapped addresses
    repeat (4) @(negedge clk);
    phaseTag = "R10";
    cmp("R10 stopped xPos", xPos, 0);
    cmp("R10 stopped de", de, 0);

    // R2..R5: run progressive, active-high syncs
    wr(0, 1);
    phaseTag = "R10";
    cmp("R10 start xPos", xPos, 0);
    cmp("R10 start yPos", yPos, 0);
    @(negedge clk);
    cmp("R10 step xPos", xPos, 1);
    phaseTag = "R4";
    waitPos(0, 0);
    cnt = 0;
    do begin
      @(negedge clk);
      if (de) cnt++;
    end while (!(xPos == 0 && yPos == 0));
    cmp("R4 de pixels per frame", cnt, 126);
    phaseTag = "R5";
    waitPos(1, 0);
    cmp("R5 vSync before edge", vSync, 0);
    @(negedge clk);
    cmp("R5 vSync at hSyncBeg", vSync, 1);
    phaseTag = "R3";
    runFrames(1);

    // R9: mid-frame line-length change and polarity change
    phaseTag = "R9";
    waitPos(5, 0);
    wr(1, 24);
    wr(0, 5);  // enable + horizontal active-low
    maxX = 0;
    do begin
      @(negedge clk);
      if (xPos > maxX) maxX = xPos;
    end while (!(xPos == 0 && yPos == 0));
    cmp("R9 old line length kept", maxX, 19);
    maxX = 0;
    do begin
      @(negedge clk);
      if (xPos > maxX) maxX = xPos;
    end while (!(xPos == 0 && yPos == 0));
    cmp("R9 new line length used", maxX, 23);

    // R10: stop mid-frame
    phaseTag = "R10";
    waitPos(4, 8);
    wr(0, 4);
    @(negedge clk);
    cmp("R10 stop xPos", xPos, 0);
    cmp("R10 stop yPos", yPos, 0);
    cmp("R10 stop hSync idle", hSync, 1);
    cmp("R10 stop de", de, 0);

    // R6..R8: interlaced, active-low syncs, field-2 sync offset of half a line
    phaseTag = "R6";
    wr(1, 20); wr(2, 6); wr(3, 2); wr(4, 4);
    wr(5, 2);  wr(6, 10); wr(7, 1); wr(8, 2);
    wr(9, 13); wr(10, 21); wr(11, 11); wr(12, 12); wr(13, 10);
    wr(0, 15);
    waitPos(0, 0);
    cnt = 0;
    do begin
      @(negedge clk);
      if (de) cnt++;
    end while (!(xPos == 0 && yPos == 0));
    cmp("R6 de pixels per frame", cnt, 224);
    phaseTag = "R7";
    waitPos(11, 11);
    cmp("R7 vSync before mid-line edge", vSync, 1);
    @(negedge clk);
    cmp("R7 vSync at mid-line edge", vSync, 0);
    waitPos(12, 11);
    cmp("R7 vSync before end edge", vSync, 0);
    @(negedge clk);
    cmp("R7 vSync released mid-line", vSync, 1);
    phaseTag = "R8";
    waitPos(15, 0);
    cmp("R8 field bottom", field, 1);
    waitPos(0, 0);
    cmp("R8 field bottom across wrap", field, 1);
    waitPos(1, 0);
    cmp("R8 field top at vSync0Beg", field, 0);
    waitPos(9, 0);
    cmp("R8 field top in first field", field, 0);
    runFrames(1);

    // R10: restart from 0,0 after a stop
    phaseTag = "R10";
    wr(0, 14);
    @(negedge clk);
    wr(0, 15);
    cmp("R10 restart xPos", xPos, 0);
    cmp("R10 restart yPos", yPos, 0);
    runFrames(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule